// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a 48-bit logical address into a 32-bit linear address. The logical address holds a 16-bit segment selector and a 32-bit offset within the segment. The low 13 selector bits index a descriptor. Selector bit 13 picks one of two descriptor tables in memory: 0 selects the global table and 1 selects the local table. The top two selector bits carry a permission value. That value is passed through and is not enforced.

Each table has a base address register and a length register. Both are loaded through a one-cycle configuration write. The length is the table's extent in bytes minus one, not an entry count. A descriptor occupies 8 bytes.

For each request the block does the following:
- It checks that the whole descriptor lies within the selected table.
- It fetches the descriptor as two 32-bit words over a valid/ready read port, low word first.
- It checks the offset against the segment bound.
- It answers with the base plus the offset, a fault code, the descriptor's attribute bits and the permission bits.

Only one translation is in flight at a time.

Top module: `seg_xlate`

## Requirements
- R1: After reset the block accepts requests (reqReady=1), raises neither rspValid nor memReqValid, and both table lengths are 0. As a result any selector gives a table fault.
- R2: A cycle with cfgWrEn=1 loads cfgBase and cfgLen into the table named by cfgTbl (0 global, 1 local). Selector bit 13 picks which table a request uses.
- R3: A descriptor fetch issues exactly two reads. The first reads address base+index*8 and returns the low word. The second reads base+index*8+4 and returns the high word. Addresses wrap modulo 2^32.
- R4: The 64-bit descriptor {high,low} is decoded as follows: attributes in bits 11:0, segment base in bits 43:12, and segment bound in bits 63:44.
- R5: With no fault, rspLinear equals segment base plus offset modulo 2^32, and rspFault=0.
- R6: When index*8+7 exceeds the selected table's length, rspFault=1, rspLinear=0 and rspAttr=0, and no memory read is issued.
- R7: When the offset exceeds the bound zero-extended to 32 bits, rspFault=2 and rspLinear=0. An offset equal to the bound is legal. The fault code 3 never appears.
- R8: The response returns the descriptor attribute bits on rspAttr and selector bits 15:14 on rspPerm.
- R9: Between acceptance of a request and consumption of its response (rspValid and rspReady both high), reqReady stays low. A response that is not taken holds all of its fields.
- R10: A memory read request holds memReqValid and memAddr until memReqReady. memRspReady is never high while a read request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Table register write strobe |
| cfgTbl | input | 1 | Table written: 0 global, 1 local |
| cfgBase | input | 32 | Table start byte address |
| cfgLen | input | 16 | Table byte length field |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqSelector | input | 16 | Segment selector |
| reqOffset | input | 32 | Intra-segment offset |
| memReqValid | output | 1 | Descriptor read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memAddr | output | 32 | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspReady | output | 1 | Block can take read data |
| memRspData | input | 32 | Read data word |
| rspValid | output | 1 | Translation result valid |
| rspReady | input | 1 | Consumer takes the result |
| rspLinear | output | 32 | Linear address (0 on fault) |
| rspFault | output | 2 | 0 none, 1 table, 2 bound |
| rspAttr | output | 12 | Descriptor attribute bits |
| rspPerm | output | 2 | Selector permission bits |

## Verification
The assertions assume the following about the block's inputs:
- The memory side never returns read data that was not asked for.
- The consumer and the memory follow valid/ready rules.

The stimulus meets these assumptions because the bench's memory model answers only after an accepted read, and it raises memRspValid only while the block waits for data. The bench also holds each request steady until it is accepted. It randomises memory and response stalls, and it draws offsets relative to the fetched bound so that offsets land on, below and just above it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W   = 32;
  localparam int SEL_W    = 16;
  localparam int IDX_W    = 13;
  localparam int LEN_W    = 16;
  localparam int ATTR_W   = 12;
  localparam int BOUND_W  = 20;
  localparam int PERM_W   = 2;
  localparam int WORD_W   = 32;
  localparam int NUM_TBL  = 2;
  localparam int ENTRY_LG = 3;                       // 8 bytes per descriptor
  localparam int DESC_W   = 2 * WORD_W;
  localparam int CHK_W    = ((IDX_W + ENTRY_LG) > LEN_W ? (IDX_W + ENTRY_LG) : LEN_W) + 1;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TABLE = 2'd1,
    FLT_BOUND = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_WT_LO, ST_RD_HI, ST_WT_HI, ST_EVAL, ST_RESP
  } state_e;

  typedef struct packed {
    logic loadReq;
    logic loadLo;
    logic loadHi;
    logic finish;
    logic hiWord;
  } strobe_t;
endpackage

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgTbl,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [SEL_W-1:0]  reqSelector,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [WORD_W-1:0] memRspData,
  input  strobe_t           stb,
  output logic              tableFault,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] rspLinear,
  output logic [1:0]        rspFault,
  output logic [ATTR_W-1:0] rspAttr,
  output logic [PERM_W-1:0] rspPerm
);
  logic [NUM_TBL-1:0][ADDR_W-1:0] tblBase;
  logic [NUM_TBL-1:0][LEN_W-1:0]  tblLen;

  // one base/length pair per descriptor table
  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [ADDR_W-1:0] baseQ;
    logic [LEN_W-1:0]  lenQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        lenQ  <= '0;
      end else if (cfgWrEn && (cfgTbl == 1'(t))) begin
        baseQ <= cfgBase;
        lenQ  <= cfgLen;
      end
    end
    assign tblBase[t] = baseQ;
    assign tblLen[t]  = lenQ;
  end

  logic [IDX_W-1:0] reqIdx;
  logic             reqTbl;
  assign reqIdx = reqSelector[IDX_W-1:0];
  assign reqTbl = reqSelector[IDX_W];

  // last byte of the entry must lie inside the table extent
  assign tableFault = CHK_W'({reqIdx, {ENTRY_LG{1'b1}}}) > CHK_W'(tblLen[reqTbl]);

  logic [ADDR_W-1:0] offQ, entryQ, linQ;
  logic [WORD_W-1:0] loQ, hiQ;
  fault_e            faultQ;
  logic [ATTR_W-1:0] attrQ;
  logic [PERM_W-1:0] permQ;

  logic [DESC_W-1:0]  desc;
  logic [ATTR_W-1:0]  descAttr;
  logic [ADDR_W-1:0]  descBase;
  logic [BOUND_W-1:0] descBound;
  assign desc      = {hiQ, loQ};
  assign descAttr  = desc[ATTR_W-1:0];
  assign descBase  = desc[ATTR_W +: ADDR_W];
  assign descBound = desc[ATTR_W+ADDR_W +: BOUND_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ   <= '0;
      entryQ <= '0;
      loQ    <= '0;
      hiQ    <= '0;
      linQ   <= '0;
      faultQ <= FLT_NONE;
      attrQ  <= '0;
      permQ  <= '0;
    end else begin
      if (stb.loadReq) begin
        offQ   <= reqOffset;
        permQ  <= reqSelector[SEL_W-1 -: PERM_W];
        entryQ <= tblBase[reqTbl] + ADDR_W'({reqIdx, {ENTRY_LG{1'b0}}});
        if (tableFault) begin
          linQ   <= '0;
          faultQ <= FLT_TABLE;
          attrQ  <= '0;
        end
      end
      if (stb.loadLo) loQ <= memRspData;
      if (stb.loadHi) hiQ <= memRspData;
      if (stb.finish) begin
        attrQ <= descAttr;
        if (offQ > ADDR_W'(descBound)) begin
          linQ   <= '0;
          faultQ <= FLT_BOUND;
        end else begin
          linQ   <= descBase + offQ;
          faultQ <= FLT_NONE;
        end
      end
    end
  end

  assign memAddr   = entryQ + (stb.hiWord ? ADDR_W'(WORD_W / 8) : '0);
  assign rspLinear = linQ;
  assign rspFault  = faultQ;
  assign rspAttr   = attrQ;
  assign rspPerm   = permQ;
endmodule

// File: rtl/seg_xlate_ctl.sv
module seg_xlate_ctl
  import seg_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    rspReady,
  input  logic    tableFault,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    memRspReady,
  output logic    rspValid,
  output strobe_t stb
);
  state_e st, nx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nx;
  end

  always_comb begin
    nx          = st;
    stb         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memRspReady = 1'b0;
    rspValid    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.loadReq = 1'b1;
          nx = tableFault ? ST_RESP : ST_RD_LO;
        end
      end
      ST_RD_LO: begin
        memReqValid = 1'b1;
        if (memReqReady) nx = ST_WT_LO;
      end
      ST_WT_LO: begin
        memRspReady = 1'b1;
        if (memRspValid) begin
          stb.loadLo = 1'b1;
          nx = ST_RD_HI;
        end
      end
      ST_RD_HI: begin
        memReqValid = 1'b1;
        stb.hiWord  = 1'b1;
        if (memReqReady) nx = ST_WT_HI;
      end
      ST_WT_HI: begin
        memRspReady = 1'b1;
        if (memRspValid) begin
          stb.loadHi = 1'b1;
          nx = ST_EVAL;
        end
      end
      ST_EVAL: begin
        stb.finish = 1'b1;
        nx = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) nx = ST_IDLE;
      end
      default: nx = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgTbl,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [SEL_W-1:0]  reqSelector,
  input  logic [ADDR_W-1:0] reqOffset,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic [WORD_W-1:0] memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspLinear,
  output logic [1:0]        rspFault,
  output logic [ATTR_W-1:0] rspAttr,
  output logic [PERM_W-1:0] rspPerm
);
  strobe_t stb;
  logic    tableFault;

  seg_xlate_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .rspReady(rspReady), .tableFault(tableFault),
    .reqReady(reqReady), .memReqValid(memReqValid), .memRspReady(memRspReady),
    .rspValid(rspValid), .stb(stb)
  );

  seg_xlate_dp u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTbl(cfgTbl), .cfgBase(cfgBase),
    .cfgLen(cfgLen), .reqSelector(reqSelector), .reqOffset(reqOffset),
    .memRspData(memRspData), .stb(stb), .tableFault(tableFault), .memAddr(memAddr),
    .rspLinear(rspLinear), .rspFault(rspFault), .rspAttr(rspAttr), .rspPerm(rspPerm)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memAddr,
  input logic        memRspReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic [31:0] rspLinear,
  input logic [1:0]  rspFault,
  input logic [11:0] rspAttr,
  input logic [1:0]  rspPerm
);
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!rspValid && !memReqValid && !memRspReady));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspLinear) && $stable(rspFault)
                                 && $stable(rspAttr) && $stable(rspPerm)));

  a_r10_memreq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memAddr)));

  a_r10_req_rsp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && memRspReady));

  a_r6_table_fault_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd1) |-> (rspLinear == '0 && rspAttr == '0));

  a_r7_bound_fault_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd2) |-> (rspLinear == '0));

  a_r7_fault_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'd3));
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgTbl = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [15:0] cfgLen = '0;
  logic reqValid = 1'b0, reqReady;
  logic [15:0] reqSelector = '0;
  logic [31:0] reqOffset = '0;
  logic memReqValid, memReqReady = 1'b0;
  logic [31:0] memAddr;
  logic memRspValid = 1'b0, memRspReady;
  logic [31:0] memRspData = '0;
  logic rspValid, rspReady = 1'b0;
  logic [31:0] rspLinear;
  logic [1:0] rspFault;
  logic [11:0] rspAttr;
  logic [1:0] rspPerm;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  int memCount = 0;
  logic [31:0] memLog [4];
  logic [31:0] shBase [2];
  logic [15:0] shLen [2];

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: answers only after an accepted read, random stalls
  initial begin
    forever begin
      @(negedge clk);
      memReqReady = ($urandom % 3) != 0;
      if (memReqValid && memReqReady) begin
        logic [31:0] a;
        a = memAddr;
        if (memCount < 4) memLog[memCount] = a;
        memCount++;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = memWord(a);
        while (!memRspReady) @(negedge clk);
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  task automatic cfgWrite(bit t, logic [31:0] b, logic [15:0] l);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgTbl = t; cfgBase = b; cfgLen = l;
    @(negedge clk);
    cfgWrEn = 1'b0;
    shBase[t] = b;
    shLen[t] = l;
  endtask

  // offMode: 0 random, 1 at or below bound, 2 equal bound, 3 bound+1
  task automatic xlate(logic [15:0] sel, int offMode);
    bit tsel;
    logic [12:0] idx;
    logic [31:0] ea, lo, hi, segBase, off, expLin;
    logic [19:0] bound;
    logic [1:0] expFault;
    logic [11:0] expAttr;
    bit tFault;
    tsel = sel[13];
    idx = sel[12:0];
    tFault = {3'b0, idx, 3'b111} > {3'b0, shLen[tsel]};
    ea = shBase[tsel] + {16'b0, idx, 3'b000};
    lo = memWord(ea);
    hi = memWord(ea + 32'd4);
    segBase = {hi[11:0], lo[31:12]};
    bound = hi[31:12];
    case (offMode)
      1: off = $urandom % ({12'b0, bound} + 32'd1);
      2: off = {12'b0, bound};
      3: off = {12'b0, bound} + 32'd1;
      default: off = $urandom;
    endcase
    if (tFault) begin
      expFault = 2'd1; expLin = '0; expAttr = '0;
    end else if (off > {12'b0, bound}) begin
      expFault = 2'd2; expLin = '0; expAttr = lo[11:0];
    end else begin
      expFault = 2'd0; expLin = segBase + off; expAttr = lo[11:0];
    end

    memCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqSelector = sel; reqOffset = off;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqSelector = $urandom; reqOffset = $urandom;
    chk(!reqReady, "R9", "reqReady after accept", 32'(reqReady), 32'd0);
    while (!rspValid) begin
      @(negedge clk);
      if (!rspValid && reqReady)
        chk(1'b0, "R9", "reqReady while busy", 32'd1, 32'd0);
    end
    repeat ($urandom % 3) begin
      logic [31:0] l0;
      l0 = rspLinear;
      @(negedge clk);
      chk(rspValid && rspLinear == l0, "R9", "held response", rspLinear, l0);
    end
    chk(rspFault == expFault, tFault ? "R6" : (expFault == 2'd2 ? "R7" : "R5"),
        "fault", 32'(rspFault), 32'(expFault));
    chk(rspLinear == expLin, expFault == 2'd0 ? "R5" : "R7", "linear", rspLinear, expLin);
    chk(rspAttr == expAttr, "R8", "attr", 32'(rspAttr), 32'(expAttr));
    chk(rspPerm == sel[15:14], "R8", "perm", 32'(rspPerm), 32'(sel[15:14]));
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R9", "idle after consume", 32'({rspValid, reqReady}), 32'b01);
    if (tFault) begin
      chk(memCount == 0, "R6", "reads on table fault", 32'(memCount), 32'd0);
    end else begin
      chk(memCount == 2, "R3", "read count", 32'(memCount), 32'd2);
      chk(memLog[0] == ea, "R3", "low word addr", memLog[0], ea);
      chk(memLog[1] == ea + 32'd4, "R3", "high word addr", memLog[1], ea + 32'd4);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    shBase[0] = '0; shBase[1] = '0; shLen[0] = '0; shLen[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "reqReady", 32'(reqReady), 32'd1);
    chk(!rspValid && !memReqValid, "R1", "valids", 32'({rspValid, memReqValid}), 32'd0);
    xlate(16'h0000, 0);                       // R1 zero-length tables fault
    xlate(16'h2000, 0);

    // R2 directed configuration
    cfgWrite(1'b0, 32'h0010_0000, 16'h00FF);
    cfgWrite(1'b1, 32'hFFFF_FF00, 16'hFFFF);
    xlate(16'h001F, 2);                       // R6 last fitting entry, R7 offset == bound
    xlate(16'h0020, 0);                       // R6 first entry past the end
    xlate(16'h7FFF, 3);                       // R7 local last entry, bound+1
    xlate(16'hC005, 1);                       // R4/R5 normal, perm 3
    xlate(16'h6005, 1);                       // R2 same index, local table
    cfgWrite(1'b1, 32'h0000_4000, 16'h0006);
    xlate(16'h2000, 0);                       // R6 length 6 faults index 0
    cfgWrite(1'b1, 32'h0000_4000, 16'h0007);
    xlate(16'h2000, 2);                       // R6 length 7 fits index 0

    for (int i = 0; i < 200; i++) begin
      logic [15:0] sel;
      if (i % 25 == 0) begin
        cfgWrite(1'b0, $urandom, 16'($urandom % 2 ? 16'hFFFF : 16'($urandom)));
        cfgWrite(1'b1, $urandom, 16'($urandom));
      end
      sel = $urandom;
      if ($urandom % 4 != 0) sel[12:0] = 13'(shLen[sel[13]] >> 3);
      xlate(sel, int'($urandom % 4));
    end
    finish_run();
  end
endmodule